// File: doc/BRIEF.md
# I2C Slave Address and Stretch Control

This block is the control core on the slave side of an I2C peripheral. It holds a 16-bit control word that software writes and reads back. Its main job is to decide whether a received address byte selects this slave. The programmed address can be 7 or 10 bits wide. Two options widen acceptance: a management mode that acknowledges every address, and a general-call option that accepts the all-zero address. The block also drives the request to hold SCL low, which stretches the clock.

A separate shift engine does the bit-level work. It reports START, STOP, each completed byte with its value, and the start of each slave transmit byte. In return this block gives a single-cycle pulse for an address match, a single-cycle pulse for a general-call interrupt, and a single-cycle pulse for the acknowledge decision. It also gives a level that asks the pad logic to hold SCL low.

The clock-release bit in the control word works with both hardware and software. Hardware clears it at fixed protocol points. How software writes to it depends on the stretch-enable bit.

Top module: `i2c_slv_addr_ctl`

## Requirements
- R1: After reset the control word reads 0x1000. Only the release bit (bit 12) is 1.
- R2: A write stores every bit except bit 14, which always reads 0. For example, a write of 0xFFFF reads back as 0xBFFF. The field positions are: bit 15 enable, bit 12 release, bit 11 acknowledge-all, bit 10 ten-bit mode, bit 7 general-call enable, bit 6 stretch enable.
- R3: While enable (bit 15) is 0, the outputs addr_match, gc_irq, ack_out and scl_hold all stay 0, even when address traffic matches.
- R4: In 7-bit mode, an address byte is the first byte_done after start_det. If its bits [7:1] equal own_addr[6:0], addr_match and ack_out pulse for one cycle, in the cycle after that byte_done. Any other byte gives neither pulse.
- R5: In 10-bit mode (bit 10 = 1), the first address byte must be 11110 followed by own_addr[9:8] in bits [2:1]. That byte gives an ack_out pulse but no match. The next byte must equal own_addr[7:0], and only then do addr_match and ack_out pulse. A wrong byte at either step gives no pulse.
- R6: With acknowledge-all (bit 11) set, any address byte gives addr_match and ack_out pulses.
- R7: With general-call enable (bit 7) set, an address byte of 0x00 gives gc_irq and ack_out pulses. With bit 7 clear, 0x00 gives no pulse unless it matches by another rule.
- R8: While the slave is addressed, a tx_start pulse clears the release bit. scl_hold is high whenever the slave is addressed and the release bit is 0. After a write that sets the release bit, scl_hold is 0 in the next cycle.
- R9: With stretch enable (bit 6) set, two things clear the release bit: a write of 0 to bit 12, and a byte_done in an addressed write transfer (R/W = 0).
- R10: With stretch enable clear, a write of 0 to bit 12 leaves the release bit unchanged, and a received data byte does not clear it.
- R11: stop_det ends the addressed state, so scl_hold drops in the next cycle. A later byte_done with no new start_det is not treated as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back |
| own_addr | input | 10 | Programmed slave address |
| start_det | input | 1 | START or repeated START seen |
| stop_det | input | 1 | STOP seen |
| byte_done | input | 1 | One byte has completed on the bus |
| rx_byte | input | 8 | Value of the completed byte |
| tx_start | input | 1 | A slave transmit byte begins |
| addr_match | output | 1 | Pulse: this slave is addressed |
| gc_irq | output | 1 | Pulse: general-call interrupt |
| ack_out | output | 1 | Pulse: acknowledge the byte just received |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench changes every input just after a falling edge. The design registers each input at the next rising edge.

The pulses addr_match, gc_irq and ack_out are due one cycle after the byte_done they answer. Each read-back value and each scl_hold change caused by a write, tx_start, a received byte or STOP is also due after that one edge. There is no longer path.

The bench therefore checks each result at the falling edge that follows the stimulus. A behavioural model, advanced on the same rising edges, gives the expected value for every output, and the outputs are also compared against it at every falling edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int unsigned CW_W     = 16;
    localparam int unsigned ADDR_W   = 10;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned B_EN     = 15;
    localparam int unsigned B_ZERO   = 14;
    localparam int unsigned B_REL    = 12;
    localparam int unsigned B_ALL    = 11;
    localparam int unsigned B_TEN    = 10;
    localparam int unsigned B_GC     = 7;
    localparam int unsigned B_STR    = 6;
    localparam logic [CW_W-1:0] CW_RST = CW_W'(1) << B_REL;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADR1, PH_ADR2, PH_LIVE, PH_SKIP
    } phase_e;

    typedef struct packed {
        logic en;
        logic rel;
        logic ack_all;
        logic ten_bit;
        logic gc_en;
        logic str_en;
    } cfg_t;
endpackage

// File: rtl/i2cs_creg.sv
module i2cs_creg
    import i2cs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CW_W-1:0] wdata,
    input  logic            hw_clr_tx,
    input  logic            hw_clr_rx,
    output cfg_t            cfg,
    output logic [CW_W-1:0] rdata
);
    typedef struct packed {
        logic [CW_W-1:0] word;
    } creg_t;

    creg_t r_d, r_q;
    logic  rel_hw;

    always_comb begin
        r_d    = r_q;
        rel_hw = r_q.word[B_REL];
        // hardware clears: every transmit start, receive end only if stretching allowed
        if (hw_clr_tx || (hw_clr_rx && r_q.word[B_STR]))
            rel_hw = 1'b0;
        r_d.word[B_REL] = rel_hw;
        if (we) begin
            r_d.word         = wdata;
            r_d.word[B_ZERO] = 1'b0;
            if (!r_q.word[B_STR])
                r_d.word[B_REL] = rel_hw | wdata[B_REL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.word <= CW_RST;
        else        r_q      <= r_d;
    end

    assign rdata       = r_q.word;
    assign cfg.en      = r_q.word[B_EN];
    assign cfg.rel     = r_q.word[B_REL];
    assign cfg.ack_all = r_q.word[B_ALL];
    assign cfg.ten_bit = r_q.word[B_TEN];
    assign cfg.gc_en   = r_q.word[B_GC];
    assign cfg.str_en  = r_q.word[B_STR];
endmodule

// File: rtl/i2cs_adec.sv
module i2cs_adec
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              hit7,
    output logic              hit10_hi,
    output logic              hit10_lo,
    output logic              gc_hit
);
    localparam int unsigned HI_W = ADDR_W - BYTE_W;

    always_comb begin
        hit7     = (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
        hit10_hi = (rx_byte[BYTE_W-1:HI_W+1] == TEN_PREFIX) &&
                   (rx_byte[HI_W:1] == own_addr[ADDR_W-1:BYTE_W]);
        hit10_lo = (rx_byte == own_addr[BYTE_W-1:0]);
        gc_hit   = (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_slv_addr_ctl.sv
module i2c_slv_addr_ctl
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CW_W-1:0]   cfg_wdata,
    output logic [CW_W-1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_start,
    output logic              addr_match,
    output logic              gc_irq,
    output logic              ack_out,
    output logic              scl_hold
);
    typedef struct packed {
        phase_e phase;
        logic   rw;
        logic   match;
        logic   gc;
        logic   ack;
    } st_t;

    st_t  s_d, s_q;
    cfg_t cfg;
    logic hit7, hit10_hi, hit10_lo, gc_hit;
    logic live, quiet_edge, clr_tx, clr_rx;
    logic take7, gc_take;

    i2cs_adec u_adec (
        .rx_byte  (rx_byte),
        .own_addr (own_addr),
        .hit7     (hit7),
        .hit10_hi (hit10_hi),
        .hit10_lo (hit10_lo),
        .gc_hit   (gc_hit)
    );

    assign live       = cfg.en && (s_q.phase == PH_LIVE);
    assign quiet_edge = !start_det && !stop_det;
    assign clr_tx     = live && quiet_edge && tx_start;
    assign clr_rx     = live && quiet_edge && byte_done && !s_q.rw;

    i2cs_creg u_creg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .hw_clr_tx (clr_tx),
        .hw_clr_rx (clr_rx),
        .cfg       (cfg),
        .rdata     (cfg_rdata)
    );

    assign take7   = cfg.ack_all || (!cfg.ten_bit && hit7);
    assign gc_take = cfg.gc_en && gc_hit;

    always_comb begin
        s_d       = s_q;
        s_d.match = 1'b0;
        s_d.gc    = 1'b0;
        s_d.ack   = 1'b0;
        if (!cfg.en || stop_det) begin
            s_d.phase = PH_IDLE;
        end else if (start_det) begin
            s_d.phase = PH_ADR1;
        end else if (byte_done) begin
            unique case (s_q.phase)
                PH_ADR1: begin
                    s_d.rw = rx_byte[0];
                    if (take7 || gc_take) begin
                        s_d.phase = PH_LIVE;
                        s_d.match = take7;
                        s_d.gc    = gc_take;
                        s_d.ack   = 1'b1;
                    end else if (cfg.ten_bit && hit10_hi) begin
                        s_d.phase = PH_ADR2;
                        s_d.ack   = 1'b1;
                    end else begin
                        s_d.phase = PH_SKIP;
                    end
                end
                PH_ADR2: begin
                    if (hit10_lo) begin
                        s_d.phase = PH_LIVE;
                        s_d.match = 1'b1;
                        s_d.ack   = 1'b1;
                    end else begin
                        s_d.phase = PH_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.rw    <= 1'b0;
            s_q.match <= 1'b0;
            s_q.gc    <= 1'b0;
            s_q.ack   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_match = cfg.en && s_q.match;
    assign gc_irq     = cfg.en && s_q.gc;
    assign ack_out    = cfg.en && s_q.ack;
    assign scl_hold   = live && !cfg.rel;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        stop_det,
    input logic        byte_done,
    input logic [7:0]  rx_byte,
    input logic        tx_start,
    input logic        addr_match,
    input logic        gc_irq,
    input logic        ack_out,
    input logic        scl_hold
);
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[15] |-> !(addr_match || gc_irq || ack_out || scl_hold));

    assert_match_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);

    assert_gc_zero_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gc_irq |-> ($past(byte_done) && $past(rx_byte) == 8'h00));

    assert_release_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && cfg_we && cfg_wdata[12] && !tx_start && !byte_done) |=> !scl_hold);

    assert_set_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_rdata[6] && cfg_rdata[12] && !tx_start) |=> cfg_rdata[12]);

    assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!scl_hold && !addr_match));
endmodule

bind i2c_slv_addr_ctl i2cs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .stop_det   (stop_det),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .tx_start   (tx_start),
    .addr_match (addr_match),
    .gc_irq     (gc_irq),
    .ack_out    (ack_out),
    .scl_hold   (scl_hold)
);

// File: tb/i2c_slv_addr_ctl_test.sv
`timescale 1ns/1ps
module i2c_slv_addr_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [9:0]  own_addr = 10'h02A;
    logic        start_det = 1'b0, stop_det = 1'b0, byte_done = 1'b0, tx_start = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        addr_match, gc_irq, ack_out, scl_hold;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    i2c_slv_addr_ctl uut (.*);

    // behavioural reference: phases 0 idle, 1 first byte, 2 second byte, 3 addressed, 4 ignored
    logic [15:0] m_reg, n_reg;
    int          m_ph, n_ph;
    logic        m_rw, m_match, m_gc, m_ack, n_rw, n_match, n_gc, n_ack, clr, keep;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 16'h1000; m_ph = 0; m_rw = 0; m_match = 0; m_gc = 0; m_ack = 0;
        end else begin
            n_ph = m_ph; n_rw = m_rw; n_match = 0; n_gc = 0; n_ack = 0;
            clr = m_reg[15] && m_ph == 3 && !start_det && !stop_det &&
                  (tx_start || (byte_done && !m_rw && m_reg[6]));
            if (!m_reg[15] || stop_det) n_ph = 0;
            else if (start_det) n_ph = 1;
            else if (byte_done && m_ph == 1) begin
                n_rw = rx_byte[0];
                if (m_reg[11] || (!m_reg[10] && rx_byte[7:1] == own_addr[6:0]) ||
                    (m_reg[7] && rx_byte == 8'h00)) begin
                    n_ph = 3; n_ack = 1;
                    n_match = m_reg[11] || (!m_reg[10] && rx_byte[7:1] == own_addr[6:0]);
                    n_gc = m_reg[7] && rx_byte == 8'h00;
                end else if (m_reg[10] && rx_byte[7:3] == 5'b11110 && rx_byte[2:1] == own_addr[9:8]) begin
                    n_ph = 2; n_ack = 1;
                end else n_ph = 4;
            end else if (byte_done && m_ph == 2) begin
                if (rx_byte == own_addr[7:0]) begin n_ph = 3; n_match = 1; n_ack = 1; end
                else n_ph = 4;
            end
            n_reg = m_reg;
            if (clr) n_reg[12] = 1'b0;
            if (cfg_we) begin
                keep = n_reg[12];
                n_reg = cfg_wdata;
                n_reg[14] = 1'b0;
                if (!m_reg[6]) n_reg[12] = keep | cfg_wdata[12];
            end
            m_reg = n_reg; m_ph = n_ph; m_rw = n_rw; m_match = n_match; m_gc = n_gc; m_ack = n_ack;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " model"},
                {cfg_rdata, 12'h0, addr_match, gc_irq, ack_out, scl_hold},
                {m_reg, 12'h0, m_match & m_reg[15], m_gc & m_reg[15], m_ack & m_reg[15],
                 m_reg[15] & (m_ph == 3) & ~m_reg[12]});
        end
    end

    task automatic wr(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_pulse();
        start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    endtask

    task automatic byte_in(input logic [7:0] b);
        byte_done = 1'b1; rx_byte = b; @(negedge clk); byte_done = 1'b0;
    endtask

    task automatic tx_pulse();
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic stop_pulse();
        stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
    endtask

    task automatic outs(input string req, input logic [3:0] exp);
        chk(req, {addr_match, gc_irq, ack_out, scl_hold}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1"; chk("R1 reset word", cfg_rdata, 16'h1000);
        outs("R1 reset outputs", 4'b0000);

        cur_req = "R2";
        wr(16'hFFFF); chk("R2 bit14 reads zero", cfg_rdata, 16'hBFFF);
        wr(16'h0000); chk("R2 clear all", cfg_rdata, 16'h0000);
        wr(16'h0040); chk("R2 stretch bit stored", cfg_rdata, 16'h0040);

        cur_req = "R3";
        start_pulse(); byte_in(8'h54); outs("R3 disabled no outputs", 4'b0000);

        cur_req = "R4";
        wr(16'h9000); chk("R4 enable word", cfg_rdata, 16'h9000);
        start_pulse(); byte_in(8'h54); outs("R4 7-bit match", 4'b1010);
        @(negedge clk); outs("R4 match is one cycle", 4'b0000);
        start_pulse(); byte_in(8'h56); outs("R4 7-bit mismatch", 4'b0000);

        cur_req = "R9";
        wr(16'h9040);
        start_pulse(); byte_in(8'h54); outs("R9 addressed", 4'b1010);
        byte_in(8'h11); outs("R9 receive stretch", 4'b0001);
        chk("R9 release cleared", cfg_rdata, 16'h8040);
        cur_req = "R8";
        wr(16'h9040); outs("R8 release drops hold", 4'b0000);
        cur_req = "R9";
        wr(16'h8040); outs("R9 software stretch", 4'b0001);
        wr(16'h9000); outs("R9 released again", 4'b0000);

        cur_req = "R10";
        wr(16'h8000); chk("R10 write zero ignored", cfg_rdata, 16'h9000);
        byte_in(8'h22); outs("R10 no receive stretch", 4'b0000);
        chk("R10 release kept", cfg_rdata, 16'h9000);

        cur_req = "R8";
        start_pulse(); byte_in(8'h55); outs("R8 read address", 4'b1010);
        tx_pulse(); outs("R8 transmit stretch", 4'b0001);
        chk("R8 release cleared", cfg_rdata, 16'h8000);
        wr(16'h9000); outs("R8 write releases", 4'b0000);

        cur_req = "R11";
        tx_pulse(); outs("R11 hold before stop", 4'b0001);
        stop_pulse(); outs("R11 stop drops hold", 4'b0000);
        byte_in(8'h55); outs("R11 no match without start", 4'b0000);
        wr(16'h9000);

        cur_req = "R5";
        own_addr = 10'h2A5;
        wr(16'h9400);
        start_pulse(); byte_in(8'hF4); outs("R5 first byte ack only", 4'b0010);
        byte_in(8'hA5); outs("R5 10-bit match", 4'b1010);
        start_pulse(); byte_in(8'hF4); byte_in(8'hA4); outs("R5 second byte mismatch", 4'b0000);
        start_pulse(); byte_in(8'hF2); outs("R5 wrong upper bits", 4'b0000);
        start_pulse(); byte_in(8'h4A); outs("R5 7-bit byte in 10-bit mode", 4'b0000);

        cur_req = "R6";
        wr(16'h9C00);
        start_pulse(); byte_in(8'h12); outs("R6 acknowledge all", 4'b1010);

        cur_req = "R7";
        wr(16'h9080);
        start_pulse(); byte_in(8'h00); outs("R7 general call", 4'b0110);
        wr(16'h9000);
        start_pulse(); byte_in(8'h00); outs("R7 general call disabled", 4'b0000);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog %s: actual=hung expected=finished", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule